// File: doc/BRIEF.md
# T1 Transmit Frame Overhead Inserter

This block paces a T1 transmit stream one bit per clock. Each frame is 193 cycles long. The first cycle carries the overhead framing bit. The next 192 cycles carry the 24 eight-bit channel slots, which are taken bit-serially from a payload input. Frames are counted into 12-frame superframes or 24-frame extended multiframes, as the format input selects.

The block outputs the serial line bit, a strobe for each framing-bit cycle, a strobe for the first frame of each group, a request that marks payload cycles, and a request that marks cycles where a data-link bit is consumed. In extended mode the block computes a six-bit check code over every multiframe and transmits it during the following multiframe.

In the twelve-frame format, an optional alarm variant gives the twelfth framing bit to a remote-alarm indication.

Top module: `t1_fbit_tx`

## Requirements
- R1: While `rst_ni` is low, `line_o`, `frame_start_o`, `mf_start_o`, `pay_req_o` and `fdl_req_o` are all 0. The first clock edge after release starts frame 1 of a group, and that cycle shows `frame_start_o` = `mf_start_o` = 1.
- R2: A frame lasts 193 cycles. Cycle 0 is the framing bit. In cycles 1 to 192, `pay_req_o` is 1 and `line_o` equals `pay_i` in the same cycle. `pay_req_o` is 0 in cycle 0.
- R3: With `esf_mode_i` = 0, the framing bits of frames 1 to 12 are 1,0,0,0,1,1,0,1,1,1,0,0. This is the odd-frame sequence 1,0,1,0,1,0 interleaved with the even-frame sequence 0,0,1,1,1,0.
- R4: With `esf_mode_i` = 0 and `j1_yellow_en_i` = 1, the framing bit of frame 12 equals `yellow_i` in that cycle. All other framing bits follow R3.
- R5: With `esf_mode_i` = 1, the framing bits of frames 4, 8, 12, 16, 20 and 24 are 0,0,1,0,1,1.
- R6: With `esf_mode_i` = 1, the framing bits of frames 2, 6, 10, 14, 18 and 22 carry the six-bit check code, most significant bit first. The code is the remainder of the previous multiframe's 4632 bits, multiplied by x^6, modulo x^6+x+1. Framing bits are counted as 1 in that sequence. The first multiframe after reset sends zeros.
- R7: With `esf_mode_i` = 1, the framing bits of the odd frames equal `fdl_i`, and `fdl_req_o` is 1 in exactly those cycles. `fdl_req_o` is 0 in the twelve-frame format.
- R8: `frame_start_o` is 1 for exactly one cycle per frame, in cycle 0. `mf_start_o` is 1 only in cycle 0 of frame 1. A group is 12 frames with `esf_mode_i` = 0 and 24 frames with `esf_mode_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one line bit per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| esf_mode_i | input | 1 | 0: 12-frame groups, 1: 24-frame groups |
| j1_yellow_en_i | input | 1 | Frame-12 framing bit carries the alarm (12-frame format) |
| yellow_i | input | 1 | Remote alarm value |
| fdl_i | input | 1 | Data-link bit, consumed when `fdl_req_o` is 1 |
| pay_i | input | 1 | Payload bit, consumed when `pay_req_o` is 1 |
| line_o | output | 1 | Serial line bit |
| frame_start_o | output | 1 | Framing-bit cycle strobe |
| mf_start_o | output | 1 | Frame-1 strobe |
| pay_req_o | output | 1 | Payload cycle |
| fdl_req_o | output | 1 | Data-link framing-bit cycle |

## Verification
The bench targets these corner cases:
- **Group wrap in each format.** A frame counter that wraps at the wrong count shifts every later pattern bit and misplaces `mf_start_o`.
- **Timing of the check code.** A design that latched the remainder one frame early, or that left out the framing bits, would send a different six-bit code. The bench catches this by doing its own polynomial long division over the captured multiframe.
- **Ordering of the check-code bits.** Sending the remainder least significant bit first also sends a different code, and the same comparison catches it.
- **Alarm slot in the twelve-frame format.** A twelfth framing bit that ignored the alarm input, or that followed it in the wrong format, is caught because `yellow_i` is changed at random.
- **Release from reset.** A late first frame or a stray strobe during reset shows up on the first compared cycles.

// File: rtl/t1_fbit_pkg.sv
package t1_fbit_pkg;
  localparam int CRC_W = 6;
  // bit i = value for pattern position i (position 0 first on the line)
  localparam logic [5:0] D4_TERM_PAT = 6'b010101;
  localparam logic [5:0] D4_SIG_PAT  = 6'b011100;
  localparam logic [5:0] ESF_FPS_PAT = 6'b110100;
  localparam logic [CRC_W-1:0] CRC_POLY = 6'b000011; // x^6 + x + 1
endpackage

// File: rtl/t1_slot_counter.sv
module t1_slot_counter #(
  parameter int CH_NUM     = 24,
  parameter int CH_BITS    = 8,
  parameter int D4_FRAMES  = 12,
  parameter int ESF_FRAMES = 24,
  parameter int BW = $clog2(CH_NUM*CH_BITS+1),
  parameter int FW = $clog2(ESF_FRAMES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          esf_i,
  output logic [BW-1:0] bit_o,
  output logic [FW-1:0] frm_o
);
  localparam int FRAME_BITS = CH_NUM*CH_BITS + 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS-1);

  logic [FW-1:0] last_frm;
  assign last_frm = esf_i ? FW'(ESF_FRAMES-1) : FW'(D4_FRAMES-1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o <= '0;
      frm_o <= '0;
    end else if (run_i) begin
      if (bit_o == LAST_BIT) begin
        bit_o <= '0;
        // >= also recovers from a format change mid-group
        frm_o <= (frm_o >= last_frm) ? '0 : frm_o + 1'b1;
      end else begin
        bit_o <= bit_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/t1_crc6_gen.sv
module t1_crc6_gen
  import t1_fbit_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             mf_first_i,
  input  logic             din_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] acc_q;

  function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] c, input logic d);
    logic fb;
    fb = c[CRC_W-1] ^ d;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      crc_o <= '0;
    end else if (run_i) begin
      if (mf_first_i) begin
        crc_o <= acc_q;              // remainder of the group just finished
        acc_q <= step('0, din_i);
      end else begin
        acc_q <= step(acc_q, din_i);
      end
    end
  end
endmodule

// File: rtl/t1_fbit_sel.sv
module t1_fbit_sel
  import t1_fbit_pkg::*;
#(
  parameter int FW        = 5,
  parameter int D4_FRAMES = 12
) (
  input  logic [FW-1:0]    frm_i,
  input  logic             esf_i,
  input  logic             j1_i,
  input  logic             yellow_i,
  input  logic             fdl_i,
  input  logic [CRC_W-1:0] crc_i,
  output logic             fbit_o,
  output logic             fdl_slot_o
);
  logic [2:0] k4, k2;
  assign k4 = 3'(frm_i >> 2);
  assign k2 = 3'(frm_i >> 1);

  always_comb begin
    fbit_o     = 1'b0;
    fdl_slot_o = 1'b0;
    if (esf_i) begin
      unique case (frm_i[1:0])
        2'b00, 2'b10: begin
          fbit_o     = fdl_i;
          fdl_slot_o = 1'b1;
        end
        2'b01:   fbit_o = crc_i[3'(CRC_W-1) - k4];
        default: fbit_o = ESF_FPS_PAT[k4];
      endcase
    end else if (!frm_i[0]) begin
      fbit_o = D4_TERM_PAT[k2];
    end else if (j1_i && frm_i == FW'(D4_FRAMES-1)) begin
      fbit_o = yellow_i;
    end else begin
      fbit_o = D4_SIG_PAT[k2];
    end
  end
endmodule

// File: rtl/t1_fbit_tx.sv
module t1_fbit_tx
  import t1_fbit_pkg::*;
#(
  parameter int CH_NUM     = 24,
  parameter int CH_BITS    = 8,
  parameter int D4_FRAMES  = 12,
  parameter int ESF_FRAMES = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic esf_mode_i,
  input  logic j1_yellow_en_i,
  input  logic yellow_i,
  input  logic fdl_i,
  input  logic pay_i,
  output logic line_o,
  output logic frame_start_o,
  output logic mf_start_o,
  output logic pay_req_o,
  output logic fdl_req_o
);
  localparam int BW = $clog2(CH_NUM*CH_BITS+1);
  localparam int FW = $clog2(ESF_FRAMES);

  logic             run_q;
  logic [BW-1:0]    bit_idx;
  logic [FW-1:0]    frm_idx;
  logic [CRC_W-1:0] crc_hold;
  logic             fbit, fdl_slot, f_cyc, mf_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  t1_slot_counter #(
    .CH_NUM(CH_NUM), .CH_BITS(CH_BITS), .D4_FRAMES(D4_FRAMES),
    .ESF_FRAMES(ESF_FRAMES), .BW(BW), .FW(FW)
  ) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .esf_i(esf_mode_i),
    .bit_o(bit_idx), .frm_o(frm_idx)
  );

  assign f_cyc  = run_q && (bit_idx == '0);
  assign mf_cyc = f_cyc && (frm_idx == '0);

  t1_crc6_gen u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .mf_first_i(mf_cyc),
    .din_i(f_cyc ? 1'b1 : pay_i), .crc_o(crc_hold)
  );

  t1_fbit_sel #(.FW(FW), .D4_FRAMES(D4_FRAMES)) u_sel (
    .frm_i(frm_idx), .esf_i(esf_mode_i), .j1_i(j1_yellow_en_i),
    .yellow_i(yellow_i), .fdl_i(fdl_i), .crc_i(crc_hold),
    .fbit_o(fbit), .fdl_slot_o(fdl_slot)
  );

  assign line_o        = f_cyc ? fbit : (run_q & pay_i);
  assign frame_start_o = f_cyc;
  assign mf_start_o    = mf_cyc;
  assign pay_req_o     = run_q && (bit_idx != '0);
  assign fdl_req_o     = f_cyc && esf_mode_i && fdl_slot;
endmodule

// File: rtl/t1_fbit_tx_chk.sv
module t1_fbit_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic esf_mode_i,
  input logic fdl_i,
  input logic line_o,
  input logic frame_start_o,
  input logic mf_start_o,
  input logic pay_req_o,
  input logic fdl_req_o
);
  assert_fs_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);
  assert_mf_in_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_start_o |-> frame_start_o);
  assert_fbit_no_pay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> !pay_req_o);
  assert_fdl_slot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fdl_req_o |-> (frame_start_o && esf_mode_i && line_o == fdl_i));
  assert_d4_first_ft_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mf_start_o && !esf_mode_i) |-> line_o);
  assert_pay_follows_fbit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> pay_req_o);
endmodule

bind t1_fbit_tx t1_fbit_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .esf_mode_i(esf_mode_i), .fdl_i(fdl_i),
  .line_o(line_o), .frame_start_o(frame_start_o), .mf_start_o(mf_start_o),
  .pay_req_o(pay_req_o), .fdl_req_o(fdl_req_o)
);

// File: tb/t1_fbit_tx_tb.sv
module t1_fbit_tx_tb;
  logic clk = 1'b0;
  logic rst_n, esf, j1, yellow, fdl, pay;
  logic line, fs, mfs, preq, freq;
  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  t1_fbit_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .esf_mode_i(esf), .j1_yellow_en_i(j1),
    .yellow_i(yellow), .fdl_i(fdl), .pay_i(pay), .line_o(line),
    .frame_start_o(fs), .mf_start_o(mfs), .pay_req_o(preq), .fdl_req_o(freq)
  );

  int d4_f[12] = '{1,0,0,0,1,1,0,1,1,1,0,0};
  int fps[6]   = '{0,0,1,0,1,1};
  bit mf_bits[$];
  logic [5:0] crc_prev;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] crc_ref();
    int rem = 0;
    for (int i = 0; i < mf_bits.size() + 6; i++) begin
      rem = (rem << 1) | ((i < mf_bits.size()) ? int'(mf_bits[i]) : 0);
      if (rem & 64) rem = rem ^ 67;
    end
    return 6'(rem);
  endfunction

  task automatic reset_check();
    chk("R1 line in reset", line, 1'b0);
    chk("R1 frame_start in reset", fs, 1'b0);
    chk("R1 mf_start in reset", mfs, 1'b0);
    chk("R1 pay_req in reset", preq, 1'b0);
    chk("R1 fdl_req in reset", freq, 1'b0);
  endtask

  task automatic run_phase(input bit esf_m, input bit j1_m, input int nframes);
    int b = 0, f = 0, nf;
    logic exp_f;
    string tag;
    @(negedge clk);
    rst_n = 1'b0; esf = esf_m; j1 = j1_m;
    @(negedge clk); #5;
    reset_check();
    @(negedge clk);
    rst_n = 1'b1;
    mf_bits.delete();
    crc_prev = '0;
    nf = esf_m ? 24 : 12;
    for (int cyc = 0; cyc < nframes * 193; cyc++) begin
      @(negedge clk);
      pay = 1'($urandom); fdl = 1'($urandom); yellow = 1'($urandom);
      #5;
      exp_f = 1'b0;
      if (b == 0) begin
        if (!esf_m) begin
          exp_f = 1'(d4_f[f]);
          tag = "R3 d4 fbit";
          if (j1_m && f == 11) begin exp_f = yellow; tag = "R4 j1 frame12"; end
        end else if (f % 4 == 3) begin
          exp_f = 1'(fps[f / 4]); tag = "R5 esf fps";
        end else if (f % 4 == 1) begin
          exp_f = crc_prev[5 - f / 4]; tag = "R6 esf crc";
        end else begin
          exp_f = fdl; tag = "R7 esf fdl";
        end
        chk(tag, line, exp_f);
      end else begin
        chk("R2 payload passthrough", line, pay);
      end
      chk("R8 frame_start", fs, b == 0);
      chk(cyc == 0 ? "R1 first mf_start" : "R8 mf_start", mfs, b == 0 && f == 0);
      chk("R2 pay_req", preq, b != 0);
      chk("R7 fdl_req", freq, esf_m && b == 0 && (f % 2 == 0));
      mf_bits.push_back(b == 0 ? 1'b1 : pay);
      b++;
      if (b == 193) begin
        b = 0; f++;
        if (f == nf) begin
          f = 0;
          crc_prev = crc_ref();
          mf_bits.delete();
        end
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; esf = 1'b0; j1 = 1'b0; yellow = 1'b0; fdl = 1'b0; pay = 1'b0;
    repeat (3) @(negedge clk);
    #5;
    reset_check();
    run_phase(1'b0, 1'b0, 36);
    run_phase(1'b0, 1'b1, 36);
    run_phase(1'b1, 1'b0, 96);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R8 watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule